// File: doc/BRIEF.md
# Dual-Channel GPIO Register Block

This block is a memory-mapped general-purpose pin peripheral. It has one or two channels, and each channel has up to 32 pins. A simple valid/write register port gives software two registers per channel. The first is an output-data register. The second is a direction register, which decides for each pin whether the block drives it or only samples it. The block exports an output value and a drive-enable for every pin, so that a pad ring outside the block can build the tri-state buffer.

Input pins pass through a two-stage synchroniser. When any pin that is set as an input changes level, in either direction, that channel's interrupt status bit is set. The bit stays set until software clears it by writing a one to it. A per-channel enable register and a single global enable bit gate the status bits onto one interrupt line. The reset values of the data and direction registers, the channel widths and the presence of the second channel are all parameters.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset:
  - each channel's output register holds its output-default parameter (0 by default);
  - each direction register holds its direction-default parameter (all ones by default);
  - each drive-enable equals the inverse of its direction register;
  - the status, enable and global-enable registers are 0, and `irq` is low.
- R2: Each register sits at a fixed byte address:
  - channel 1 data is at 0x000 and channel 1 direction is at 0x004;
  - channel 2 data is at 0x008 and channel 2 direction is at 0x00C;
  - a write (`bus_valid` and `bus_write` high at a rising clock edge) updates the register at that edge;
  - a read (`bus_valid` high, `bus_write` low) returns the register contents combinationally on `bus_rdata`.
- R3: A direction bit of 1 makes the pin an input, and its drive-enable is 0. A direction bit of 0 makes the pin an output: its drive-enable is 1, and its output value is the corresponding output-register bit.
- R4: A read of a data register returns, bit by bit:
  - for input bits, the pin level delayed through the two synchroniser stages;
  - for output bits, the output-register bit.
- R5: The status register is at 0x120, with bit 0 for channel 1 and bit 1 for channel 2.
  - A status bit is set within three clock edges after any input-direction pin of its channel changes level, whether it rises or falls.
  - Level changes on output-direction pins do not set it.
- R6: A status bit stays set until software writes a 1 to that bit at 0x120. This holds even if the pin returns to its earlier level. Writing 0, or writing a 1 to the other channel's bit, leaves it set.
- R7: The per-channel enable register is at 0x128, using the status bit layout. The global enable is bit 31 at 0x11C. `irq` is high exactly when the global enable is 1 and (status AND enable) is nonzero.
- R8: The following read as 0, and writes to them have no effect:
  - any offset not listed in R2, R5 or R7;
  - bits above a channel's width;
  - bits 30..0 of 0x11C;
  - bits 31..2 of 0x120 and 0x128.
- R9: With the dual-channel parameter cleared:
  - the channel 2 data and direction registers read 0;
  - bit 1 of 0x128 cannot be set;
  - status bit 1 is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is requested |
| pins0_in | input | CH0_W | Channel 1 pin levels (asynchronous) |
| pins0_out | output | CH0_W | Channel 1 output values |
| pins0_oe | output | CH0_W | Channel 1 drive-enables, 1 = drive |
| pins1_in | input | CH1_W | Channel 2 pin levels (asynchronous) |
| pins1_out | output | CH1_W | Channel 2 output values |
| pins1_oe | output | CH1_W | Channel 2 drive-enables |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench targets four kinds of corner case:
- **Mixed-direction data register.** A design that returns only the pins, or only the output register, gives a wrong readback.
- **Pin toggles on output-direction bits.** A design without direction masking raises a false interrupt.
- **Sticky status.** A design that clears on a wrong-bit write, on a zero write, or when the pin level is restored loses the event. A design that ignores the write-one-to-clear leaves `irq` stuck high.
- **Narrow second channel and single-channel build.** These expose upper bits that are not masked, and a second status bit that can still be reached.

// File: rtl/pin_bank_pkg.sv
`timescale 1ns/1ps
package pin_bank_pkg;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned GIE_BIT = 31;

   localparam logic [31:0] OFS_DATA0 = 32'h0000_0000;
   localparam logic [31:0] OFS_DIR0  = 32'h0000_0004;
   localparam logic [31:0] OFS_DATA1 = 32'h0000_0008;
   localparam logic [31:0] OFS_DIR1  = 32'h0000_000C;
   localparam logic [31:0] OFS_GIE   = 32'h0000_011C;
   localparam logic [31:0] OFS_STAT  = 32'h0000_0120;
   localparam logic [31:0] OFS_IEN   = 32'h0000_0128;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_DATA0, SEL_DIR0, SEL_DATA1, SEL_DIR1,
      SEL_GIE, SEL_STAT, SEL_IEN
   } reg_sel_e;

   // Channel 2 registers decode only when the second channel exists
   function automatic reg_sel_e decode_addr(input logic [31:0] a, input bit dual);
      reg_sel_e s;
      s = SEL_NONE;
      if (a == OFS_DATA0)              s = SEL_DATA0;
      else if (a == OFS_DIR0)          s = SEL_DIR0;
      else if (a == OFS_DATA1 && dual) s = SEL_DATA1;
      else if (a == OFS_DIR1 && dual)  s = SEL_DIR1;
      else if (a == OFS_GIE)           s = SEL_GIE;
      else if (a == OFS_STAT)          s = SEL_STAT;
      else if (a == OFS_IEN)           s = SEL_IEN;
      return s;
   endfunction

endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);

   logic [W-1:0] stage1_q;
   logic [W-1:0] stage2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1_q <= '0;
         stage2_q <= '0;
      end else begin
         stage1_q <= async_in;
         stage2_q <= stage1_q;
      end
   end

   assign sync_out = stage2_q;

endmodule

// File: rtl/pin_channel.sv
`timescale 1ns/1ps
module pin_channel #(
   parameter int unsigned W        = 32,
   parameter logic [31:0] DOUT_RST = 32'h0000_0000,
   parameter logic [31:0] DIR_RST  = 32'hFFFF_FFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_data,
   input  logic         wr_dir,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pins_in,
   output logic [W-1:0] pins_out,
   output logic [W-1:0] pins_oe,
   output logic [W-1:0] rd_data,
   output logic [W-1:0] rd_dir,
   output logic         change
);

   localparam logic [W-1:0] DOUT_INIT = DOUT_RST[W-1:0];
   localparam logic [W-1:0] DIR_INIT  = DIR_RST[W-1:0];
   localparam int unsigned  WARM_N    = 3;

   logic [W-1:0]      pin_s;
   logic [W-1:0]      prev_q;
   logic [W-1:0]      dout_q;
   logic [W-1:0]      dir_q;
   logic [WARM_N-1:0] warm_q;

   pin_sync #(.W(W)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pins_in),
      .sync_out (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= DOUT_INIT;
         dir_q  <= DIR_INIT;
         prev_q <= '0;
         warm_q <= '0;
      end else begin
         if (wr_data) dout_q <= wdata;
         if (wr_dir)  dir_q  <= wdata;
         prev_q <= pin_s;
         warm_q <= {warm_q[WARM_N-2:0], 1'b1};
      end
   end

   // Edges are ignored until the synchroniser holds real pin samples
   assign change   = warm_q[WARM_N-1] & |((pin_s ^ prev_q) & dir_q);
   assign pins_out = dout_q;
   assign pins_oe  = ~dir_q;
   assign rd_data  = (pin_s & dir_q) | (dout_q & ~dir_q);
   assign rd_dir   = dir_q;

endmodule

// File: rtl/pin_irq_ctrl.sv
`timescale 1ns/1ps
module pin_irq_ctrl #(
   parameter int unsigned NCH = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] chg,
   input  logic       wr_stat,
   input  logic       wr_ien,
   input  logic       wr_gie,
   input  logic [1:0] wd_low,
   input  logic       wd_gie,
   output logic [1:0] stat_q,
   output logic [1:0] ien_q,
   output logic       gie_q,
   output logic       irq
);

   localparam logic [1:0] CH_MASK = (NCH == 2) ? 2'b11 : 2'b01;

   logic [1:0] clr;
   logic [1:0] stat_d;

   // A new event in the same cycle as a clear wins, so no edge is lost
   assign clr    = wr_stat ? wd_low : 2'b00;
   assign stat_d = ((stat_q & ~clr) | chg) & CH_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         ien_q  <= '0;
         gie_q  <= 1'b0;
      end else begin
         stat_q <= stat_d;
         if (wr_ien) ien_q <= wd_low & CH_MASK;
         if (wr_gie) gie_q <= wd_gie;
      end
   end

   assign irq = gie_q & |(stat_q & ien_q);

endmodule

// File: rtl/pin_bank_ctrl.sv
`timescale 1ns/1ps
module pin_bank_ctrl #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned CH0_W     = 32,
   parameter int unsigned CH1_W     = 32,
   parameter bit          DUAL      = 1'b1,
   parameter logic [31:0] CH0_DOUT  = 32'h0000_0000,
   parameter logic [31:0] CH0_DIR   = 32'hFFFF_FFFF,
   parameter logic [31:0] CH1_DOUT  = 32'h0000_0000,
   parameter logic [31:0] CH1_DIR   = 32'hFFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [CH0_W-1:0]  pins0_in,
   output logic [CH0_W-1:0]  pins0_out,
   output logic [CH0_W-1:0]  pins0_oe,
   input  logic [CH1_W-1:0]  pins1_in,
   output logic [CH1_W-1:0]  pins1_out,
   output logic [CH1_W-1:0]  pins1_oe,
   output logic              irq
);
   import pin_bank_pkg::*;

   localparam int unsigned NCH = DUAL ? 2 : 1;

   if (CH0_W < 1 || CH0_W > 32) begin : g_bad_w0
      $error("pin_bank_ctrl: CH0_W must lie in 1..32");
   end
   if (CH1_W < 1 || CH1_W > 32) begin : g_bad_w1
      $error("pin_bank_ctrl: CH1_W must lie in 1..32");
   end
   if (ADDR_W < 9 || ADDR_W > 32) begin : g_bad_aw
      $error("pin_bank_ctrl: ADDR_W must lie in 9..32");
   end

   reg_sel_e   sel;
   logic       wr_en;
   logic [1:0] chg;
   logic [1:0] irq_stat_q;
   logic [1:0] irq_ien_q;
   logic       irq_gie_q;

   logic [CH0_W-1:0] ch0_rd;
   logic [CH0_W-1:0] ch0_dir;
   logic [CH1_W-1:0] ch1_rd;
   logic [CH1_W-1:0] ch1_dir;

   assign sel   = decode_addr(32'(bus_addr), DUAL);
   assign wr_en = bus_valid & bus_write;

   pin_channel #(.W(CH0_W), .DOUT_RST(CH0_DOUT), .DIR_RST(CH0_DIR)) i_ch0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_data  (wr_en && sel == SEL_DATA0),
      .wr_dir   (wr_en && sel == SEL_DIR0),
      .wdata    (bus_wdata[CH0_W-1:0]),
      .pins_in  (pins0_in),
      .pins_out (pins0_out),
      .pins_oe  (pins0_oe),
      .rd_data  (ch0_rd),
      .rd_dir   (ch0_dir),
      .change   (chg[0])
   );

   if (DUAL) begin : g_ch1
      pin_channel #(.W(CH1_W), .DOUT_RST(CH1_DOUT), .DIR_RST(CH1_DIR)) i_ch1 (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_data  (wr_en && sel == SEL_DATA1),
         .wr_dir   (wr_en && sel == SEL_DIR1),
         .wdata    (bus_wdata[CH1_W-1:0]),
         .pins_in  (pins1_in),
         .pins_out (pins1_out),
         .pins_oe  (pins1_oe),
         .rd_data  (ch1_rd),
         .rd_dir   (ch1_dir),
         .change   (chg[1])
      );
   end else begin : g_no_ch1
      logic unused_pins1;
      assign unused_pins1 = ^pins1_in;
      assign pins1_out    = '0;
      assign pins1_oe     = '0;
      assign ch1_rd       = '0;
      assign ch1_dir      = '0;
      assign chg[1]       = 1'b0;
   end

   pin_irq_ctrl #(.NCH(NCH)) i_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .chg     (chg),
      .wr_stat (wr_en && sel == SEL_STAT),
      .wr_ien  (wr_en && sel == SEL_IEN),
      .wr_gie  (wr_en && sel == SEL_GIE),
      .wd_low  (bus_wdata[1:0]),
      .wd_gie  (bus_wdata[GIE_BIT]),
      .stat_q  (irq_stat_q),
      .ien_q   (irq_ien_q),
      .gie_q   (irq_gie_q),
      .irq     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_valid && !bus_write) begin
         unique case (sel)
            SEL_DATA0: bus_rdata = 32'(ch0_rd);
            SEL_DIR0:  bus_rdata = 32'(ch0_dir);
            SEL_DATA1: bus_rdata = 32'(ch1_rd);
            SEL_DIR1:  bus_rdata = 32'(ch1_dir);
            SEL_GIE:   bus_rdata = {irq_gie_q, 31'd0};
            SEL_STAT:  bus_rdata = {30'd0, irq_stat_q};
            SEL_IEN:   bus_rdata = {30'd0, irq_ien_q};
            default:   bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/pin_bank_chk.sv
`timescale 1ns/1ps
module pin_bank_chk #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned CH0_W  = 32,
   parameter bit          DUAL   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [CH0_W-1:0]  pins0_oe,
   input logic [1:0]        stat,
   input logic              gie,
   input logic              irq
);

   logic [31:0] a32;
   logic        is_stat_wr;
   logic        is_dir0_wr;
   logic        hole_rd;

   assign a32        = 32'(bus_addr);
   assign is_stat_wr = bus_valid && bus_write && a32 == 32'h120;
   assign is_dir0_wr = bus_valid && bus_write && a32 == 32'h004;
   assign hole_rd    = bus_valid && !bus_write &&
                       !(a32 == 32'h000 || a32 == 32'h004 || a32 == 32'h008 ||
                         a32 == 32'h00C || a32 == 32'h11C || a32 == 32'h120 ||
                         a32 == 32'h128);

   // R6
   stat0_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat[0] && !(is_stat_wr && bus_wdata[0]) |=> stat[0]);

   // R6
   stat1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat[1] && !(is_stat_wr && bus_wdata[1]) |=> stat[1]);

   // R3
   dir0_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_dir0_wr |=> pins0_oe == ~$past(bus_wdata[CH0_W-1:0]));

   // R7
   gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq);

   // R8
   hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hole_rd |-> bus_rdata == 32'd0);

   if (!DUAL) begin : g_single
      // R9
      no_ch1_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         stat[1] == 1'b0);
   end

endmodule

bind pin_bank_ctrl pin_bank_chk #(.ADDR_W(ADDR_W), .CH0_W(CH0_W), .DUAL(DUAL)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pins0_oe  (pins0_oe),
   .stat      (irq_stat_q),
   .gie       (irq_gie_q),
   .irq       (irq)
);

// File: tb/test_pin_bank_ctrl.sv
`timescale 1ns/1ps
module test_pin_bank_ctrl;

   localparam int unsigned AW = 12;
   localparam int unsigned W1 = 12;
   localparam int unsigned NV = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_write = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   rdata_m;
   logic [31:0]   rdata_s;
   logic [31:0]   p0 = '0;
   logic [W1-1:0] p1 = '0;
   logic [31:0]   sp0 = '0;
   logic [31:0]   sp1 = '0;
   logic [31:0]   out0, oe0, sout0, soe0, sout1, soe1;
   logic [W1-1:0] out1, oe1;
   logic          irq_m, irq_s;
   logic [31:0]   rd;
   int            checks = 0;
   int            fails  = 0;
   bit            done   = 1'b0;

   always #2.5 clk = ~clk;

   pin_bank_ctrl #(.ADDR_W(AW), .CH0_W(32), .CH1_W(W1), .DUAL(1'b1),
                   .CH1_DOUT(32'h0000_0A5A), .CH1_DIR(32'h0000_0F0F)) i_pin_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_m),
      .pins0_in(p0), .pins0_out(out0), .pins0_oe(oe0),
      .pins1_in(p1), .pins1_out(out1), .pins1_oe(oe1), .irq(irq_m));

   pin_bank_ctrl #(.ADDR_W(AW), .DUAL(1'b0)) i_pin_bank_ctrl_single (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_s),
      .pins0_in(sp0), .pins0_out(sout0), .pins0_oe(soe0),
      .pins1_in(sp1), .pins1_out(sout1), .pins1_oe(soe1), .irq(irq_s));

   // {address, write data, expected readback}
   localparam logic [95:0] VEC [NV] = '{
      {32'h004, 32'h0000_0000, 32'h0000_0000},
      {32'h000, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
      {32'h00C, 32'hFFFF_FFFF, 32'h0000_0FFF},
      {32'h008, 32'hFFFF_FFFF, 32'h0000_0000},
      {32'h00C, 32'h0000_0000, 32'h0000_0000},
      {32'h008, 32'hFFFF_FFFF, 32'h0000_0FFF},
      {32'h11C, 32'hFFFF_FFFF, 32'h8000_0000},
      {32'h11C, 32'h0000_0000, 32'h0000_0000},
      {32'h128, 32'hFFFF_FFFF, 32'h0000_0003},
      {32'h128, 32'h0000_0000, 32'h0000_0000},
      {32'h0F0, 32'hFFFF_FFFF, 32'h0000_0000},
      {32'h124, 32'hFFFF_FFFF, 32'h0000_0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd_both(input logic [31:0] a, output logic [31:0] m, output logic [31:0] s);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = AW'(a);
      #1;
      m = rdata_m; s = rdata_s;
      bus_valid = 1'b0;
   endtask

   task automatic rd_main(input logic [31:0] a, output logic [31:0] m);
      logic [31:0] s;
      rd_both(a, m, s);
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R1 reset state
      check("R1 oe0", oe0, 32'h0);
      check("R1 out0", out0, 32'h0);
      check("R1 oe1", 32'(oe1), 32'h0F0);
      check("R1 out1", 32'(out1), 32'hA5A);
      check("R1 irq", 32'(irq_m), 32'h0);
      rd_main(32'h004, rd); check("R1 dir0", rd, 32'hFFFF_FFFF);
      rd_main(32'h120, rd); check("R1 stat", rd, 32'h0);

      // R2 / R8 register table
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][95:64], VEC[i][63:32]);
         rd_main(VEC[i][95:64], rd);
         check($sformatf("R2/R8 vec %0d", i), rd, VEC[i][31:0]);
      end
      check("R3 all-output oe0", oe0, 32'hFFFF_FFFF);
      check("R3 out0 drives register", out0, 32'hDEAD_BEEF);

      // R4 mixed direction readback
      wr(32'h004, 32'hFFFF_0000);
      wr(32'h000, 32'h0000_1234);
      check("R3 split oe0", oe0, 32'h0000_FFFF);
      p0 = 32'hABCD_FFFF;
      settle();
      rd_main(32'h000, rd); check("R4 mixed read", rd, 32'hABCD_1234);
      rd_main(32'h120, rd); check("R5 input change sets stat0", rd, 32'h1);
      wr(32'h120, 32'h3);
      rd_main(32'h120, rd); check("R6 w1c clears", rd, 32'h0);

      // R5 output-direction toggle ignored
      p0 = p0 ^ 32'h1;
      settle();
      rd_main(32'h120, rd); check("R5 output pin ignored", rd, 32'h0);

      // R5 falling edge on input
      p0[31] = 1'b0;
      settle();
      rd_main(32'h120, rd); check("R5 falling sets", rd, 32'h1);
      wr(32'h120, 32'h1);
      p0[31] = 1'b1;
      settle();
      rd_main(32'h120, rd); check("R5 rising sets", rd, 32'h1);

      // R6 sticky behaviour
      repeat (10) @(negedge clk);
      wr(32'h120, 32'h0);
      rd_main(32'h120, rd); check("R6 zero write keeps", rd, 32'h1);
      wr(32'h120, 32'h2);
      rd_main(32'h120, rd); check("R6 other bit keeps", rd, 32'h1);

      // R7 gating
      wr(32'h11C, 32'h8000_0000);
      check("R7 enable off", 32'(irq_m), 32'h0);
      wr(32'h128, 32'h1);
      check("R7 all enabled", 32'(irq_m), 32'h1);
      wr(32'h11C, 32'h7FFF_FFFF);
      check("R7 global off", 32'(irq_m), 32'h0);
      wr(32'h11C, 32'h8000_0000);
      check("R7 global on", 32'(irq_m), 32'h1);
      wr(32'h120, 32'h1);
      check("R6 clear drops irq", 32'(irq_m), 32'h0);

      // Channel 2 events
      wr(32'h128, 32'h2);
      wr(32'h00C, 32'h0000_000F);
      p1 = 12'h100;
      settle();
      rd_main(32'h120, rd); check("R5 ch2 output toggle ignored", rd, 32'h0);
      p1 = 12'h101;
      settle();
      rd_main(32'h120, rd); check("R5 ch2 sets bit1", rd, 32'h2);
      check("R7 ch2 irq", 32'(irq_m), 32'h1);
      rd_main(32'h008, rd); check("R4 ch2 mixed read", rd, 32'h0000_0FF1);

      // R9 single-channel build
      wr(32'h008, 32'hFFFF_FFFF);
      rd_both(32'h008, rd, s); check("R9 ch2 data absent", s, 32'h0);
      rd_both(32'h00C, rd, s); check("R9 ch2 dir absent", s, 32'h0);
      wr(32'h128, 32'h3);
      rd_both(32'h128, rd, s); check("R9 enable bit1 blocked", s, 32'h1);
      sp1 = 32'hFFFF_FFFF;
      settle();
      rd_both(32'h120, rd, s); check("R9 no ch2 status", s, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule